// File: doc/BRIEF.md
# GPIO Input Glitch Filter

This block cleans up one general-purpose input line before its level reaches the data read path and the edge or level interrupt logic. The raw pin has already passed through a synchronizer. A new level is accepted only after the pin has disagreed with the current filtered level for a programmed number of sample ticks in a row. A power-of-two prescaler sets the spacing of those ticks. The length of the filter window is therefore `count × 2^select` core clocks. With a 2.5 ns core clock, the usual setting of select 4 and count 9 gives a window of 144 clocks, which is about 360 ns and close to the intended 400 ns. The longest window is 15 × 2^15 clocks.

Two 4-bit inputs program the filter. `filt_count_i` is the number of ticks the pin must stay changed. `filt_shift_i` is the prescaler exponent. Any pair of values from 0 to 15 is legal, since the software that fills these fields rounds its result up and can land on any of them. A count of zero turns the filter off, and the output then follows the pin in the same cycle. If the select value changes, the prescaler restarts, so a new window always begins from a known phase.

Top module: `gpio_deglitch`

## Requirements
- R1: While `rst_ni` is low, `level_o` is 0 whenever `filt_count_i` is nonzero, and the filter holds no partial count once reset is released.
- R2: When `filt_count_i` is 0, `level_o` equals `pin_i` in the same cycle.
- R3: With `filt_shift_i` at 0 and `filt_count_i` = N > 0, a pin change that then holds steady shows on `level_o` at exactly the N-th rising clock edge after the change.
- R4: With `filt_shift_i` at 0 and `filt_count_i` = N, a pulse that lasts N−1 clock edges or fewer leaves `level_o` unchanged.
- R5: The stability count clears as soon as the pin returns to the filtered level, so short pulses separated by a single matching cycle do not add up.
- R6: A change of `filt_shift_i` restarts the prescaler. The first tick then comes 2^select edges later, so a pin change made in the cycle after a select change shows after exactly `count × 2^select` edges.
- R7: While the settings stay unchanged, `level_o` moves only after the pin has differed from it for at least `(count−1) × 2^select + 1` and at most `count × 2^select` consecutive edges. It never moves while the pin agrees with it.
- R8: Rising and falling pin changes are filtered the same way.
- R9: When the count goes from 0 to a nonzero value, `level_o` continues from the pin level sampled at the last clock edge, with no extra transition.
- R10: The full select range is honoured: select 15 with count 1 needs 32768 steady edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Synchronized raw pin level |
| filt_count_i | input | CNT_W (4) | Ticks of steady disagreement needed; 0 disables the filter |
| filt_shift_i | input | SEL_W (4) | Prescaler exponent: one tick every 2^value clocks |
| level_o | output | 1 | Filtered pin level |

## Verification
If the prescaler phase is corrupted, the output still changes, but at the wrong edge. A settled change after a select restart lands off its exact `count × 2^select` edge within one window. A stability count that fails to clear, or that wraps, shows up within two short pulses: `level_o` accepts a pulse that should have been rejected, or holds a steady change past the upper bound. A filtered level flop that is stuck or stale is visible either at once in bypass or when bypass is left, because `level_o` must then match the pin value from the previous edge.

// File: rtl/gpio_deglitch.sv
module gpio_deglitch #(
  parameter int CNT_W = 4,
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] filt_count_i,
  input  logic [SEL_W-1:0] filt_shift_i,
  output logic             level_o
);

  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] shift_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_top;
  logic [CNT_W:0]   stab_next;
  logic [CNT_W-1:0] stab_q;
  logic             level_q;
  logic             restart, tick, bypass, differ;

  assign pre_top   = ~({PRE_W{1'b1}} << filt_shift_i);
  assign restart   = filt_shift_i != shift_q;
  assign tick      = !restart && (pre_q == pre_top);
  assign bypass    = filt_count_i == '0;
  assign differ    = pin_i != level_q;
  assign stab_next = {1'b0, stab_q} + 1'b1;
  assign level_o   = bypass ? pin_i : level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      pre_q   <= '0;
    end else begin
      shift_q <= filt_shift_i;
      if (restart || tick) pre_q <= '0;
      else                 pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stab_q  <= '0;
      level_q <= 1'b0;
    end else if (bypass) begin
      stab_q  <= '0;
      level_q <= pin_i;
    end else if (!differ) begin
      stab_q  <= '0;
    end else if (tick) begin
      if (stab_next >= {1'b0, filt_count_i}) begin
        stab_q  <= '0;
        level_q <= pin_i;
      end else begin
        stab_q  <= stab_next[CNT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/gpio_deglitch_chk.sv
module gpio_deglitch_chk #(
  parameter int CNT_W = 4,
  parameter int SEL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pin_i,
  input logic [CNT_W-1:0] filt_count_i,
  input logic [SEL_W-1:0] filt_shift_i,
  input logic             level_o
);

  localparam int RUN_W = (1 << SEL_W) + CNT_W + 1;

  logic [CNT_W-1:0] cnt_d;
  logic [SEL_W-1:0] sel_d;
  logic             lvl_d;
  logic [RUN_W-1:0] run_q;
  logic             dirty_q;
  logic             cfg_chg, mis;
  logic [RUN_W-1:0] hi_bound, lo_bound;

  assign cfg_chg  = (filt_count_i != cnt_d) || (filt_shift_i != sel_d);
  assign mis      = pin_i != level_o;
  assign hi_bound = RUN_W'(filt_count_i) << filt_shift_i;
  assign lo_bound = (RUN_W'(filt_count_i) - 1'b1) << filt_shift_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_d   <= '0;
      sel_d   <= '0;
      lvl_d   <= 1'b0;
      run_q   <= '0;
      dirty_q <= 1'b0;
    end else begin
      cnt_d <= filt_count_i;
      sel_d <= filt_shift_i;
      lvl_d <= level_o;
      if (!mis || filt_count_i == '0) begin
        run_q   <= '0;
        dirty_q <= 1'b0;
      end else if (cfg_chg) begin
        run_q   <= '0;
        dirty_q <= 1'b1;
      end else if (level_o != lvl_d) begin
        run_q   <= 1;
        dirty_q <= 1'b0;
      end else begin
        run_q   <= run_q + 1'b1;
      end
    end
  end

  // R7 upper bound
  p_window_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_count_i != '0 && mis && !cfg_chg && level_o == lvl_d) |-> run_q < hi_bound);

  // R7 lower bound, R4
  p_window_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != $past(level_o) && filt_count_i != '0 && filt_count_i == $past(filt_count_i)
     && $past(filt_count_i != '0 && mis && !cfg_chg && !dirty_q))
    |-> $past(run_q) >= $past(lo_bound));

  p_hold_on_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(filt_count_i != '0 && !mis) && filt_count_i != '0) |-> $stable(level_o));

  p_bypass_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_count_i != '0 && $past(filt_count_i) == '0) |-> level_o == $past(pin_i));

  always_comb begin
    if (!rst_ni && filt_count_i != '0) p_reset_low_r1: assert (level_o == 1'b0);
  end

endmodule

bind gpio_deglitch gpio_deglitch_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i),
  .filt_count_i(filt_count_i), .filt_shift_i(filt_shift_i), .level_o(level_o)
);

// File: tb/test_gpio_deglitch.sv
`timescale 1ns/1ps
module test_gpio_deglitch;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic [3:0] cnt = 4'd5;
  logic [3:0] sel = 4'd0;
  logic       level;
  int         n_chk = 0;
  int         n_err = 0;

  always #4 clk = ~clk;

  gpio_deglitch i_gpio_deglitch (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin),
    .filt_count_i(cnt), .filt_shift_i(sel), .level_o(level)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input logic v);
    @(negedge clk);
    cnt = 4'd0;
    pin = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic arm(input logic [3:0] c, input logic [3:0] s);
    cnt = c;
    sel = s + 4'd1;
    @(negedge clk);
    sel = s;
    @(negedge clk);
  endtask

  task automatic measure(input logic v, input int max, output int n);
    n = 0;
    pin = v;
    for (int i = 1; i <= max; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (level == v) begin
        n = i;
        return;
      end
    end
  endtask

  task automatic t_reset;
    pin = 1'b1;
    #1;
    chk("R1 reset level", level, 0);
    pin = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", level, 0);
  endtask

  task automatic t_bypass;
    settle(1'b0);
    pin = 1'b1;
    #1;
    chk("R2 bypass rise", level, 1);
    pin = 1'b0;
    #1;
    chk("R2 bypass fall", level, 0);
  endtask

  task automatic t_exact_sel0;
    int n;
    settle(1'b0);
    arm(4'd5, 4'd0);
    measure(1'b1, 20, n);
    chk("R3 latency count5", n, 5);
    settle(1'b0);
    arm(4'd1, 4'd0);
    measure(1'b1, 20, n);
    chk("R3 latency count1", n, 1);
  endtask

  task automatic t_glitch;
    int seen = 0;
    settle(1'b0);
    arm(4'd5, 4'd0);
    pin = 1'b1;
    repeat (4) @(negedge clk);
    pin = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (level) seen = 1;
    end
    chk("R4 short pulse rejected", seen, 0);
  endtask

  task automatic t_no_accumulate;
    int seen = 0;
    settle(1'b0);
    arm(4'd6, 4'd0);
    for (int k = 0; k < 3; k++) begin
      pin = 1'b1;
      repeat (4) begin
        @(negedge clk);
        if (level) seen = 1;
      end
      pin = 1'b0;
      @(negedge clk);
      if (level) seen = 1;
    end
    chk("R5 pulses do not add up", seen, 0);
  endtask

  task automatic t_prescale;
    int n;
    settle(1'b0);
    arm(4'd3, 4'd2);
    measure(1'b1, 40, n);
    chk("R6 latency 3x4", n, 12);
    settle(1'b0);
    arm(4'd9, 4'd4);
    measure(1'b1, 300, n);
    chk("R6 latency 9x16", n, 144);
  endtask

  task automatic t_window_bounds;
    int seen = 0;
    int n;
    settle(1'b0);
    arm(4'd9, 4'd4);
    repeat (7) @(negedge clk);
    pin = 1'b1;
    repeat (100) begin
      @(negedge clk);
      if (level) seen = 1;
    end
    pin = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (level) seen = 1;
    end
    chk("R7 100-cycle pulse rejected at 9x16", seen, 0);
    repeat (5) @(negedge clk);
    measure(1'b1, 300, n);
    chk("R7 latency at least 129", int'(n >= 129), 1);
    chk("R7 latency at most 144", int'(n <= 144 && n > 0), 1);
  endtask

  task automatic t_falling;
    int n;
    settle(1'b1);
    arm(4'd3, 4'd0);
    measure(1'b0, 20, n);
    chk("R8 falling latency", n, 3);
    settle(1'b1);
    arm(4'd2, 4'd1);
    measure(1'b0, 20, n);
    chk("R8 falling latency prescaled", n, 4);
  endtask

  task automatic t_bypass_exit;
    int seen = 0;
    settle(1'b1);
    cnt = 4'd3;
    #1;
    chk("R9 level kept on leaving bypass", level, 1);
    repeat (10) begin
      @(negedge clk);
      if (!level) seen = 1;
    end
    chk("R9 no transition after bypass", seen, 0);
  endtask

  task automatic t_max_select;
    int n;
    settle(1'b0);
    arm(4'd1, 4'd15);
    measure(1'b1, 40000, n);
    chk("R10 select 15 latency", n, 32768);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_bypass();
    t_exact_sel0();
    t_glitch();
    t_no_accumulate();
    t_prescale();
    t_window_bounds();
    t_falling();
    t_bypass_exit();
    t_max_select();
    finish_run();
  end

endmodule